// File: doc/BRIEF.md
# Clock Configuration Register Unit with Feed Unlock

This unit holds the settings for a core clock generator. Software writes an enable bit, a connect bit, a multiplier field and a post-divider code into shadow registers. The shadow registers have no effect on the generator until software writes a two-value key to the feed register. The key is 0xAA and then 0x55, as consecutive writes. When the second key value arrives, the shadow values are copied into the active registers, and the active registers drive the generator outputs. This guards the clock settings against stray writes.

A read-only status register reports the active settings together with a lock flag. The lock flag is taken from a lock input, which stands in for the analog loop. The connect output is gated by that lock flag. A separate peripheral-divider register sets the rate of a clock-enable pulse for peripherals: every core cycle, every second cycle or every fourth cycle. Writes to the peripheral-divider register take effect at once, without the feed key.

Top module: `clkcfg_unit`

Register addresses on `wr_addr` / `rd_addr`: 0 = control, 1 = configuration, 2 = feed on write and status on read, 3 = peripheral divider.

## Requirements
- R1: After reset, every shadow register and every active register reads zero, the peripheral divider reads 0, and `pll_en`, `pll_conn`, `pll_mult_m1` and `pll_div_code` are all zero.
- R2: A write to control (data bit 0 = enable, bit 1 = connect) or to configuration (bits [4:0] = multiplier minus one, bits [6:5] = divider code) is visible on read of the same address from the next cycle. It leaves the active outputs unchanged.
- R3: A 0x55 feed write that follows a 0xAA feed write, with no other write in between, copies all shadow fields to the active outputs on the clock edge that accepts the 0x55 write. Idle cycles without any write may separate the two feed writes.
- R4: The sequence is aborted by any write to another address after 0xAA, or by a feed value other than 0xAA or 0x55. A 0x55 with no armed 0xAA is ignored. In each of these cases the active outputs keep their values.
- R5: Reading address 2 returns the active multiplier in [4:0], the active divider code in [6:5], active enable in bit 8, active connect in bit 9 and the lock input in bit 10. All other bits read zero.
- R6: `pll_conn` is high only while the active enable bit, the active connect bit and `lock_in` are all high.
- R7: With peripheral divider 1, `pclk_en` is high on every cycle. The divider value is readable at address 3 and takes effect without a feed.
- R8: With peripheral divider 2, `pclk_en` is high on one cycle in two.
- R9: With peripheral divider 0 or 3, `pclk_en` is high on one cycle in four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| lock_in | input | 1 | Lock indication from the clock generator |
| pll_en | output | 1 | Active enable |
| pll_conn | output | 1 | Active connect, gated by enable and lock |
| pll_mult_m1 | output | 5 | Active multiplier minus one |
| pll_div_code | output | 2 | Active post-divider code (0..3 means 1,2,4,8) |
| pclk_en | output | 1 | Peripheral clock-enable pulse |

## Verification
The feed logic is tried with five patterns:
- the clean key;
- the key with idle cycles between its two halves;
- a lone 0x55;
- a key broken by a configuration write;
- a key broken by a foreign feed value.

Together these separate a detector that needs strict adjacency from one that forgets its armed state, and from one that ignores interleaved writes.

The lock input is toggled while the active connect bit is both set and clear. This shows that the connect output and status bit 10 follow the lock input independently. It also shows that a shadow change does not move the outputs before the next key.

The peripheral divider is stepped through all four codes. The pulse count in a fixed window tells the three rates apart, and it confirms that code 3 aliases code 0.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int MULT_W = 5;
    localparam int DIV_W  = 2;
    localparam int WR_W   = 8;
    localparam int RD_W   = 16;
    localparam int ADDR_W = 2;
    localparam int LOCK_BIT = 10;
    localparam int EN_BIT   = 8;
    localparam int CONN_BIT = 9;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FEED = 2'd2;
    localparam logic [ADDR_W-1:0] A_PDIV = 2'd3;

    localparam logic [WR_W-1:0] KEY_ARM    = 8'hAA;
    localparam logic [WR_W-1:0] KEY_COMMIT = 8'h55;

    typedef struct packed {
        logic              en;
        logic              conn;
        logic [DIV_W-1:0]  div;
        logic [MULT_W-1:0] mult;
    } clk_set_t;
endpackage

// File: rtl/clkcfg_feed.sv
module clkcfg_feed
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    output logic              commit
);
    typedef struct packed {
        logic armed;
    } feed_st_t;

    feed_st_t st_d, st_q;
    logic     feed_wr;

    always_comb begin
        st_d    = st_q;
        feed_wr = wr_en && (wr_addr == A_FEED);
        commit  = feed_wr && (wr_data == KEY_COMMIT) && st_q.armed;
        if (wr_en) begin
            // any write re-evaluates the arm state; only 0xAA on feed arms
            st_d.armed = feed_wr && (wr_data == KEY_ARM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a write elsewhere between the keys must block the commit
    a_r4_other_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != A_FEED) |=> !commit);

    // R4: a foreign feed value must block the commit
    a_r4_bad_key_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FEED && wr_data != KEY_ARM && wr_data != KEY_COMMIT) |=> !commit);
endmodule

// File: rtl/clkcfg_pdiv.sv
module clkcfg_pdiv
    import clkcfg_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    output logic [1:0]        sel,
    output logic              pclk_en
);
    typedef struct packed {
        logic [1:0]       sel;
        logic [CNT_W-1:0] cnt;
    } pdiv_st_t;

    pdiv_st_t         st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d = st_q;
        unique case (st_q.sel)
            2'b01:   last = CNT_W'(0);
            2'b10:   last = CNT_W'(1);
            default: last = CNT_W'(3);
        endcase
        if (st_q.cnt >= last) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + CNT_W'(1);
        if (wr_en && wr_addr == A_PDIV) st_d.sel = wr_data[1:0];
        pclk_en = (st_q.cnt == '0);
        sel     = st_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: full rate once divider 1 has been in force for a cycle
    a_r7_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && $past(sel) == 2'b01) |-> pclk_en);

    // R8: half rate never gives two pulses in a row
    a_r8_half_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en && sel == 2'b10) |=> !pclk_en);

    // R9: quarter rate never gives two pulses in a row
    a_r9_quarter_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en && (sel == 2'b00 || sel == 2'b11)) |=> !pclk_en);
endmodule

// File: rtl/clkcfg_unit.sv
module clkcfg_unit
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data,
    input  logic              lock_in,
    output logic              pll_en,
    output logic              pll_conn,
    output logic [MULT_W-1:0] pll_mult_m1,
    output logic [DIV_W-1:0]  pll_div_code,
    output logic              pclk_en
);
    typedef struct packed {
        clk_set_t shadow;
        clk_set_t active;
    } regs_t;

    regs_t      r_d, r_q;
    logic       commit;
    logic [1:0] pdiv_sel;

    clkcfg_feed u_feed (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit)
    );

    clkcfg_pdiv #(.CNT_W(2)) u_pdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel     (pdiv_sel),
        .pclk_en (pclk_en)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en && wr_addr == A_CTRL) begin
            r_d.shadow.en   = wr_data[0];
            r_d.shadow.conn = wr_data[1];
        end
        if (wr_en && wr_addr == A_CFG) begin
            r_d.shadow.mult = wr_data[MULT_W-1:0];
            r_d.shadow.div  = wr_data[MULT_W+DIV_W-1:MULT_W];
        end
        if (commit) r_d.active = r_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: rd_data[1:0] = {r_q.shadow.conn, r_q.shadow.en};
            A_CFG:  rd_data[MULT_W+DIV_W-1:0] = {r_q.shadow.div, r_q.shadow.mult};
            A_FEED: begin
                rd_data[MULT_W+DIV_W-1:0] = {r_q.active.div, r_q.active.mult};
                rd_data[EN_BIT]   = r_q.active.en;
                rd_data[CONN_BIT] = r_q.active.conn;
                rd_data[LOCK_BIT] = lock_in;
            end
            default: rd_data[1:0] = pdiv_sel;
        endcase
    end

    assign pll_en       = r_q.active.en;
    assign pll_mult_m1  = r_q.active.mult;
    assign pll_div_code = r_q.active.div;
    assign pll_conn     = r_q.active.conn && r_q.active.en && lock_in;

    // R2, R4: without a commit the active outputs hold
    a_r4_hold_without_key: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ({pll_en, pll_div_code, pll_mult_m1} ==
                     $past({pll_en, pll_div_code, pll_mult_m1})));

    // R3: a commit delivers the shadow fields to the outputs
    a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ({pll_en, pll_div_code, pll_mult_m1} ==
                    $past({r_q.shadow.en, r_q.shadow.div, r_q.shadow.mult})));

    // R6: connect output requires lock and enable
    a_r6_conn_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pll_conn |-> (lock_in && pll_en));
endmodule

// File: tb/clkcfg_unit_tb.sv
module clkcfg_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        lock_in = 1'b0;
    logic        pll_en, pll_conn, pclk_en;
    logic [4:0]  pll_mult_m1;
    logic [1:0]  pll_div_code;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int          port;   // 0..3 read address, 4 = output vector
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    clkcfg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .lock_in(lock_in), .pll_en(pll_en), .pll_conn(pll_conn),
        .pll_mult_m1(pll_mult_m1), .pll_div_code(pll_div_code),
        .pclk_en(pclk_en)
    );

    task automatic score(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected items and compares against the design
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] got;
            it = sb_q.pop_front();
            if (it.port < 4) rd_addr = 2'(it.port);
            #1;
            if (it.port < 4) got = rd_data;
            else got = {7'b0, pll_en, pll_conn, pll_div_code, pll_mult_m1};
            score(it.req, got, it.exp);
        end
    end

    task automatic expect_item(input int port, input logic [15:0] exp, input string req);
        item_t it;
        @(posedge clk); #1;
        it.port = port; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        @(negedge clk); #2;
    endtask

    // outputs vector: {en, conn, div[1:0], mult[4:0]}
    function automatic logic [15:0] outv(input logic en, input logic cn,
                                         input logic [1:0] dv, input logic [4:0] m);
        return {7'b0, en, cn, dv, m};
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pclk_count(input logic [1:0] code, input int exp, input string req);
        int cnt = 0;
        bus_wr(2'd3, {6'b0, code});
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            cnt += int'(pclk_en);
        end
        score(req, 16'(cnt), 16'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_item(0, 16'h0000, "R1 ctrl");
        expect_item(1, 16'h0000, "R1 cfg");
        expect_item(2, 16'h0000, "R1 status");
        expect_item(3, 16'h0000, "R1 pdiv");
        expect_item(4, 16'h0000, "R1 outputs");
        pclk_count(2'd0, 2, "R9 reset rate");

        // R2 shadow writes
        bus_wr(2'd0, 8'h03);
        bus_wr(2'd1, 8'h24);
        expect_item(0, 16'h0003, "R2 ctrl shadow");
        expect_item(1, 16'h0024, "R2 cfg shadow");
        expect_item(4, 16'h0000, "R2 outputs unchanged");

        // R4 lone commit key
        bus_wr(2'd2, 8'h55);
        expect_item(4, 16'h0000, "R4 lone 0x55");
        // R4 key broken by other write
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd1, 8'h24);
        bus_wr(2'd2, 8'h55);
        expect_item(4, 16'h0000, "R4 interleaved write");
        // R4 key broken by foreign value
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd2, 8'h12);
        bus_wr(2'd2, 8'h55);
        expect_item(4, 16'h0000, "R4 foreign key");

        // R3 key with idle cycles between halves, lock low
        bus_wr(2'd2, 8'hAA);
        repeat (3) @(negedge clk);
        bus_wr(2'd2, 8'h55);
        expect_item(4, outv(1, 0, 2'd1, 5'd4), "R3 commit, R6 no lock");
        expect_item(2, 16'h0324, "R5 status lock low");

        // R6 lock high
        @(negedge clk); lock_in = 1'b1;
        expect_item(4, outv(1, 1, 2'd1, 5'd4), "R6 connect with lock");
        expect_item(2, 16'h0724, "R5 status lock high");

        // R2 new shadow ignored until key, R3 then applies it
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd1, 8'h67);
        expect_item(4, outv(1, 1, 2'd1, 5'd4), "R2 shadow not applied");
        bus_wr(2'd2, 8'hAA);
        bus_wr(2'd2, 8'h55);
        expect_item(4, outv(1, 0, 2'd3, 5'd7), "R3 second commit, R6 conn clear");
        expect_item(2, 16'h0567, "R5 status after commit");
        @(negedge clk); lock_in = 1'b0;
        expect_item(2, 16'h0167, "R5 status lock dropped");

        // peripheral divider rates
        pclk_count(2'd1, 8, "R7 divide by 1");
        expect_item(3, 16'h0001, "R7 pdiv readback");
        pclk_count(2'd2, 4, "R8 divide by 2");
        pclk_count(2'd3, 2, "R9 code 3 as divide by 4");
        pclk_count(2'd0, 2, "R9 code 0 divide by 4");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule